// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block produces a periodic interrupt request at a fixed rate of 100 events per second, counted down from the system clock. A free-running prescaler divides the clock by `CLK_HZ / TICK_HZ` and emits a one-cycle tick. When the timer's interrupt-enable flag is set, each tick raises a request. The request stays raised until software clears it.

Software reaches the timer through a single processor-register port. A write strobe with write data updates the control/status register. The read data always shows the current register contents. The only implemented bit is the interrupt-enable flag at bit 6. Writing that bit as zero disables the timer and also drops any request that is pending. Bit 7 is the tick-acknowledge ("done") bit, and setting it in a write has no visible effect. Every other bit is ignored on a write and reads back as zero.

The asynchronous active-low reset is released through a two-stage synchronizer. All timer state therefore stays cleared until the second rising clock edge after `rst_n` goes high.

Top module: `itick_timer`

## Requirements
- R1: While `rst_n` is low, `reg_rdata` and `irq_o` are zero, and this takes effect without waiting for a clock edge. A write captured at either of the first two rising edges after `rst_n` rises is discarded.
- R2: `reg_rdata` carries the enable flag at bit 6, and every other bit of `reg_rdata` is zero.
- R3: A write is `reg_we` high at a rising edge. It loads `reg_wdata[6]` into the enable flag, and no other written bit is stored.
- R4: The prescaler raises a one-cycle tick once every `CLK_HZ / TICK_HZ` cycles. When a tick arrives while the enable flag is 1, `irq_o` becomes 1 at the next rising edge.
- R5: Once `irq_o` is 1, it stays 1 through any number of further ticks until a clearing write or a reset.
- R6: Setting bit 7 (done) in a write, with bit 6 also set, changes neither `irq_o` nor `reg_rdata`.
- R7: A write with bit 6 equal to 0 clears `irq_o` at that edge. A write with bit 6 equal to 1 leaves a pending request in place.
- R8: The request-setting edges of consecutive ticks are exactly `CLK_HZ / TICK_HZ` cycles apart.
- R9: A tick that arrives while the enable flag is 0 does not set `irq_o`. When a clearing write lands on the same edge as a tick, the clear wins. When an enabling write lands on a tick edge, that tick is not caught.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data (bit 6 enable, bit 7 done) |
| reg_rdata | output | DATA_W | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The enable flag is written with all-ones, with all-ones minus bit 6, with bit 6 alone and with bits 6 and 7 together. These patterns separate the single stored bit from the bits that are ignored, and separate the done bit from the enable bit. Requests are observed for a long time with enable off and after many ticks with a request pending, which separates "set on tick" from "set while enabled" and from "auto-clear". Writes are aligned to land exactly on a known tick edge, once as a clear and once as an enable. This pins down the same-edge priority and the exact tick period. A write placed in the two edges after reset release shows that the reset synchronizer holds the state.

// File: rtl/itick_pkg.sv
package itick_pkg;

  // Bit positions inside the control/status register.
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned DONE_BIT = 7;

  // Number of clock cycles between ticks.
  function automatic int unsigned calc_div(input int unsigned clk_hz,
                                           input int unsigned tick_hz);
    return clk_hz / tick_hz;
  endfunction

endpackage

// File: rtl/itick_rst_sync.sv
module itick_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/itick_prescaler.sv
module itick_prescaler #(
  parameter int unsigned DIV = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = wrap ? '0 : cnt_q + CNT_W'(1);
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R4/R8: a tick is a single-cycle pulse
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  // R8: the counter never leaves its range
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8: a tick is seen only right after the counter has wrapped
  p_tick_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (cnt_q == '0));

endmodule

// File: rtl/itick_csr.sv
module itick_csr
  import itick_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ie_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic ie_q, ie_d;
  logic ie_load;
  logic unused_wbits;

  // Only the enable bit is stored; the rest, including done, is dropped.
  assign unused_wbits = ^{wr_data_i[DATA_W-1:IE_BIT+1], wr_data_i[IE_BIT-1:0]};

  always_comb begin
    ie_load = wr_en_i;
    ie_d    = wr_data_i[IE_BIT];
    clr_o   = wr_en_i & ~wr_data_i[IE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (ie_load) ie_q <= ie_d;
  end

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[IE_BIT] = ie_q;
  end

  assign ie_o = ie_q;

  // R3: enable holds its value when there is no write
  p_ie_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ie_q));
  // R7: a clearing write leaves the enable flag at zero
  p_clr_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !ie_q);

endmodule

// File: rtl/itick_irq_req.sv
module itick_irq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ie_i,
  input  logic clr_i,
  output logic irq_o
);

  logic req_q, req_d;
  logic set_req;

  always_comb begin
    set_req = tick_i & ie_i;
    if (clr_i)        req_d = 1'b0;
    else if (set_req) req_d = 1'b1;
    else              req_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign irq_o = req_q;

  // R4: an enabled tick raises the request
  p_set_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && ie_i && !clr_i) |=> req_q);
  // R5: a pending request is sticky
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !clr_i) |=> req_q);
  // R7: a clearing write drops the request
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !req_q);
  // R9: no request appears without an enabled tick
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(tick_i && ie_i)) |=> !req_q);

endmodule

// File: rtl/itick_timer.sv
module itick_timer
  import itick_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned TICK_HZ = 100,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam int unsigned DIV = calc_div(CLK_HZ, TICK_HZ);

  logic rst_sync_n;
  logic tick;
  logic ie;
  logic clr;

  itick_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  itick_prescaler #(.DIV(DIV)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  itick_csr #(.DATA_W(DATA_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (reg_we),
    .wr_data_i (reg_wdata),
    .ie_o      (ie),
    .clr_o     (clr),
    .rd_data_o (reg_rdata)
  );

  itick_irq_req u_irq_req (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick),
    .ie_i   (ie),
    .clr_i  (clr),
    .irq_o  (irq_o)
  );

  // R2: only bit 6 can ever read as one
  p_rdata_mask_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata & ~(DATA_W'(1) << IE_BIT)) == '0);
  // R3: a write's bit 6 appears on the read port
  p_ie_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> (reg_rdata[IE_BIT] == $past(reg_wdata[IE_BIT])));
  // R6: a write keeping enable set never drops a pending request
  p_done_keeps_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o && reg_we && reg_wdata[IE_BIT]) |=> irq_o);

endmodule

// File: tb/test_itick_timer.sv
module test_itick_timer;

  localparam int CLK_HZ  = 10_000;
  localparam int TICK_HZ = 100;
  localparam int DIV     = CLK_HZ / TICK_HZ;
  localparam int DW      = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  itick_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .DATA_W(DW)) i_itick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq)
  );

  typedef struct {
    string         req;
    logic [DW-1:0] rd;
    logic          irq;
    bit            chk_rd;
    bit            chk_irq;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      if (e.chk_rd) begin
        checks++;
        if (reg_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", e.req, reg_rdata, e.rd);
        end
      end
      if (e.chk_irq) begin
        checks++;
        if (irq !== e.irq) begin
          errors++;
          $display("FAIL %s: irq actual %b expected %b", e.req, irq, e.irq);
        end
      end
    end
  end

  task automatic expect_now(string req, logic [DW-1:0] rd, logic ir,
                            bit chk_rd, bit chk_irq);
    exp_t e;
    e.req = req; e.rd = rd; e.irq = ir; e.chk_rd = chk_rd; e.chk_irq = chk_irq;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(logic [DW-1:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  // Drive a write so it is captured at the edge whose index is target.
  task automatic write_at(int target, logic [DW-1:0] d);
    while (cyc < target - 1) @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_irq(int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq === 1'b1) begin
        at = cyc;
        break;
      end
    end
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3;
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    idle(3);
    expect_now("R1", '0, 1'b0, 1, 1);               // reset state
    rst_n = 1'b1;
    do_write(32'h40);                               // lands in the sync window
    expect_now("R1", '0, 1'b0, 1, 1);

    idle(3 * DIV);
    expect_now("R9", '0, 1'b0, 1, 1);               // disabled ticks do nothing

    do_write(32'hFFFF_FFFF);
    expect_now("R2", 32'h40, 1'b0, 1, 0);
    do_write(32'hFFFF_FFBF);
    expect_now("R3", '0, 1'b0, 1, 1);
    do_write(32'h40);
    expect_now("R3", 32'h40, 1'b0, 1, 0);

    wait_irq(DIV + 10, t0);
    check_val("R4", (t0 >= 0) ? 1 : 0, 1);
    expect_now("R4", 32'h40, 1'b1, 1, 1);

    idle(2 * DIV + 7);
    expect_now("R5", 32'h40, 1'b1, 1, 1);           // sticky across ticks

    do_write(32'hC0);
    expect_now("R6", 32'h40, 1'b1, 1, 1);
    do_write(32'hFFFF_FFFF);
    expect_now("R6", 32'h40, 1'b1, 1, 1);

    do_write(32'h40);
    expect_now("R7", 32'h40, 1'b1, 1, 1);
    do_write(32'h0);
    expect_now("R7", '0, 1'b0, 1, 1);

    idle(2 * DIV);
    expect_now("R9", '0, 1'b0, 1, 1);

    do_write(32'h40);
    wait_irq(DIV + 10, t1);
    do_write(32'h0);
    do_write(32'h40);
    wait_irq(DIV + 10, t2);
    check_val("R8", t2 - t1, DIV);

    // Same-edge priority, aligned on known tick edges.
    do_write(32'h0);
    do_write(32'h40);
    write_at(t2 + DIV, 32'h0);                      // clear on a tick edge
    expect_now("R9", '0, 1'b0, 1, 1);
    write_at(t2 + 2 * DIV, 32'h40);                 // enable on a tick edge
    expect_now("R9", 32'h40, 1'b0, 1, 1);
    wait_irq(DIV + 10, t3);
    check_val("R8", t3, t2 + 3 * DIV);

    rst_n = 1'b0;
    #1;
    check_val("R1", int'(irq), 0);
    check_val("R1", int'(reg_rdata), 0);
    expect_now("R1", '0, 1'b0, 1, 1);

    finish_run();
  end

endmodule